// File: doc/BRIEF.md
# MDIO Register Auto-Poll Engine

This block watches up to two registers inside external Ethernet PHY devices without host involvement. On every poll tick it walks through its active poll slots in a fixed order. For each slot it runs one MII management read frame on the MDC/MDIO pins and compares the 16-bit result with the value that slot read last time. When the value has changed, the slot's interrupt bit is set. The bit stays set until the host clears it. The most recent value read for each slot is always shown on an output bus.

Slot 0 is always active. It reads status register 1 of the default PHY, whose address comes from a configuration input. Slot 1 is programmable and is active only while both its own enable and the global auto-poll enable are high. It can target any PHY address and register number, and it can drop the frame preamble. It can also be told to follow the default PHY instead. In that mode the preamble is dropped only when a status flag reports that the default PHY accepts frames without a preamble. MDC runs continuously from a programmable divider of the system clock. All configuration and status pins are plain levels or one-cycle pulses, and there is no back-pressure anywhere.

Top module: `mdio_autopoll`

## Requirements
- R1: On each accepted poll tick, slot 0 reads register number 1 of the PHY at `dflt_phy_addr`. Its frame always carries the full 32-bit preamble.
- R2: Slot 1 is read in a round only when `slot1_en` and `ap_global_en` are both 1. Otherwise a round contains the slot 0 frame alone.
- R3: When `s1_use_dflt` is 0, slot 1 reads register `s1_reg_addr` of the PHY at `s1_phy_addr`. Its preamble is left out exactly when `s1_pre_sup` is 1.
- R4: When `s1_use_dflt` is 1, slot 1 ignores `s1_phy_addr` and `s1_pre_sup`. It reads `s1_reg_addr` of the PHY at `dflt_phy_addr`, and leaves the preamble out exactly when `dflt_no_pre_ok` is 1.
- R5: A read frame is sent in this order:
  - 32 driven ones (unless suppressed);
  - start bits 0,1 and opcode bits 1,0;
  - the 5-bit PHY address, MSB first;
  - the 5-bit register number, MSB first;
  - two turnaround bits with MDIO released (`mdio_oe`=0);
  - 16 data bits, MSB first, sampled from `mdio_i`.
- R6: MDC has a period of 2*CLK_DIV system clocks. `mdio_o` and `mdio_oe` change only in the clock where MDC falls. Read data is sampled in the clock where MDC rises.
- R7: The first read of a slot after reset, or after slot 1 becomes enabled again, only loads the reference value and leaves that slot's interrupt bit unchanged.
- R8: A read whose value differs from the slot's previous read sets bit n of `irq` for slot n. The bit stays set until a one-cycle pulse on the same bit of `irq_clr`.
- R9: Within a round, slot 0 is read before slot 1. `busy` is 1 from the cycle after an accepted tick until the round ends, and a `poll_tick` seen while `busy` is 1 is ignored.
- R10: `s0_data` and `s1_data` hold the last value read by each slot, and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_tick | input | 1 | One-cycle request to start a poll round |
| ap_global_en | input | 1 | Global enable for the programmable slot |
| slot1_en | input | 1 | Enable of slot 1 |
| dflt_phy_addr | input | 5 | Address of the default PHY |
| s1_phy_addr | input | 5 | Slot 1 PHY address |
| s1_reg_addr | input | 5 | Slot 1 register number |
| s1_pre_sup | input | 1 | Slot 1 preamble suppression |
| s1_use_dflt | input | 1 | Slot 1 follows the default PHY |
| dflt_no_pre_ok | input | 1 | Default PHY accepts preamble-less frames |
| irq_clr | input | 2 | Write-one-to-clear pulses for the interrupt bits |
| mdio_i | input | 1 | MDIO line as seen by the block |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| irq | output | 2 | Sticky change-interrupt bits, bit n for slot n |
| s0_data | output | 16 | Last value read by slot 0 |
| s1_data | output | 16 | Last value read by slot 1 |
| busy | output | 1 | A poll round is in progress |

## Verification
The bench builds the block with CLK_DIV=2. A full frame then takes 256 system clocks, which leaves room for dozens of complete poll rounds, including rounds with and without preamble. The address width stays at 5 bits and the preamble length at 32. This lets a bench-side PHY model decode every PHY address and register number, count the preamble bits of every frame, and answer from a full 32-by-32 register table. Random configuration rounds mix default-PHY substitution, slot 1 gating and changed or unchanged register contents. Directed rounds cover re-enabling, clearing, and a tick issued in the middle of a round.

// File: rtl/mdio_ap_pkg.sv
package mdio_ap_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_S0,
    SQ_S1
  } seq_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_ARM,
    F_RUN
  } frm_t;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic       no_pre;
  } rd_req_t;

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LIM = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == LIM);
  assign rise_stb = wrap & ~mdc;
  assign fall_stb = wrap & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_rise_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
  assert_fall_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc);

endmodule

// File: rtl/mdio_rd_frame.sv
module mdio_rd_frame
  import mdio_ap_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rd_req_t           req,
  input  logic              fall_stb,
  input  logic              rise_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int HDR_W   = 4 + 2 * ADDR_W;
  localparam int FRAME   = PRE_BITS + HDR_W + 2 + DATA_W;
  localparam int PW      = $clog2(FRAME + 1);
  localparam logic [PW-1:0] P_HDR  = PW'(PRE_BITS);
  localparam logic [PW-1:0] P_TA   = PW'(PRE_BITS + HDR_W);
  localparam logic [PW-1:0] P_DAT  = PW'(PRE_BITS + HDR_W + 2);
  localparam logic [PW-1:0] P_LAST = PW'(FRAME - 1);

  frm_t              st;
  logic [PW-1:0]     nxt, cur;
  logic [HDR_W-1:0]  hdr_sh;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= F_IDLE;
      nxt     <= '0;
      cur     <= '0;
      hdr_sh  <= '0;
      shreg   <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: begin
          if (start) begin
            hdr_sh <= {2'b01, 2'b10, req.phy, req.regn};
            nxt    <= req.no_pre ? P_HDR : '0;
            st     <= F_ARM;
          end
        end
        default: begin
          if (fall_stb) begin
            cur <= nxt;
            nxt <= nxt + 1'b1;
            st  <= F_RUN;
            if (nxt < P_HDR) begin
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b1;
            end else if (nxt < P_TA) begin
              mdio_o  <= hdr_sh[HDR_W-1];
              mdio_oe <= 1'b1;
              hdr_sh  <= hdr_sh << 1;
            end else begin
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b0;
            end
          end else if (rise_stb && st == F_RUN && cur >= P_DAT) begin
            shreg <= {shreg[DATA_W-2:0], mdio_i};
            if (cur == P_LAST) begin
              rdata <= {shreg[DATA_W-2:0], mdio_i};
              done  <= 1'b1;
              st    <= F_IDLE;
            end
          end
        end
      endcase
    end
  end

  assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> $stable(mdio_o) && $stable(mdio_oe));
  assert_released_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && st == F_RUN && cur >= P_TA) |-> !mdio_oe);

endmodule

// File: rtl/ap_slot.sv
module ap_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              upd,
  input  logic [DATA_W-1:0] rdata,
  input  logic              clr,
  output logic [DATA_W-1:0] data,
  output logic              irq
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data   <= '0;
      primed <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (!en) begin
        primed <= 1'b0;
      end else if (upd) begin
        data   <= rdata;
        primed <= 1'b1;
      end
      if (en && upd && primed && rdata != data) irq <= 1'b1;
      else if (clr) irq <= 1'b0;
    end
  end

  assert_first_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd && !primed && !irq) |=> !irq);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr && !upd) |=> !irq);
  assert_ref_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd) |=> data == $past(rdata));

endmodule

// File: rtl/mdio_autopoll.sv
module mdio_autopoll
  import mdio_ap_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_tick,
  input  logic              ap_global_en,
  input  logic              slot1_en,
  input  logic [4:0]        dflt_phy_addr,
  input  logic [4:0]        s1_phy_addr,
  input  logic [4:0]        s1_reg_addr,
  input  logic              s1_pre_sup,
  input  logic              s1_use_dflt,
  input  logic              dflt_no_pre_ok,
  input  logic [1:0]        irq_clr,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [1:0]        irq,
  output logic [DATA_W-1:0] s0_data,
  output logic [DATA_W-1:0] s1_data,
  output logic              busy
);
  localparam int NSLOT = 2;
  localparam logic [4:0] STATUS_REG = 5'd1;

  logic              rise_stb, fall_stb;
  logic              f_start, f_done;
  logic [DATA_W-1:0] f_rdata;
  rd_req_t           req_q, req0, req1;
  seq_t              sq_q;
  logic              s1_act;
  logic [NSLOT-1:0]  slot_en, slot_upd;
  logic [DATA_W-1:0] slot_data [NSLOT];

  assign s1_act = slot1_en & ap_global_en;
  assign busy   = (sq_q != SQ_IDLE);

  always_comb begin
    req0.phy    = dflt_phy_addr;
    req0.regn   = STATUS_REG;
    req0.no_pre = 1'b0;
    req1.phy    = s1_use_dflt ? dflt_phy_addr : s1_phy_addr;
    req1.regn   = s1_reg_addr;
    req1.no_pre = s1_use_dflt ? dflt_no_pre_ok : s1_pre_sup;
    slot_en     = {s1_act, 1'b1};
    slot_upd    = {f_done && sq_q == SQ_S1, f_done && sq_q == SQ_S0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q    <= SQ_IDLE;
      f_start <= 1'b0;
      req_q   <= '0;
    end else begin
      f_start <= 1'b0;
      case (sq_q)
        SQ_IDLE: if (poll_tick) begin
          f_start <= 1'b1;
          req_q   <= req0;
          sq_q    <= SQ_S0;
        end
        SQ_S0: if (f_done) begin
          if (s1_act) begin
            f_start <= 1'b1;
            req_q   <= req1;
            sq_q    <= SQ_S1;
          end else begin
            sq_q <= SQ_IDLE;
          end
        end
        default: if (f_done) sq_q <= SQ_IDLE;
      endcase
    end
  end

  mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_rd_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(f_start), .req(req_q),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(f_done), .rdata(f_rdata)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    ap_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .en(slot_en[g]), .upd(slot_upd[g]),
      .rdata(f_rdata), .clr(irq_clr[g]), .data(slot_data[g]), .irq(irq[g])
    );
  end

  assign s0_data = slot_data[0];
  assign s1_data = slot_data[1];

  assert_slot0_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q == SQ_IDLE) |=> (sq_q != SQ_S1));
  assert_tick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q == SQ_S1 && !f_done) |=> (sq_q == SQ_S1));
  assert_s1_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q == SQ_S0 && f_done && !s1_act) |=> !busy);

endmodule

// File: tb/tb_mdio_autopoll.sv
module tb_mdio_autopoll;
  localparam int CLK_DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic poll_tick = 0, ap_global_en = 0, slot1_en = 0;
  logic [4:0] dflt_phy_addr = 0, s1_phy_addr = 0, s1_reg_addr = 0;
  logic s1_pre_sup = 0, s1_use_dflt = 0, dflt_no_pre_ok = 0;
  logic [1:0] irq_clr = 0;
  logic mdio_i;
  logic mdc, mdio_o, mdio_oe, busy;
  logic [1:0] irq;
  logic [15:0] s0_data, s1_data;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  mdio_autopoll #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick), .ap_global_en(ap_global_en),
    .slot1_en(slot1_en), .dflt_phy_addr(dflt_phy_addr), .s1_phy_addr(s1_phy_addr),
    .s1_reg_addr(s1_reg_addr), .s1_pre_sup(s1_pre_sup), .s1_use_dflt(s1_use_dflt),
    .dflt_no_pre_ok(dflt_no_pre_ok), .irq_clr(irq_clr), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq),
    .s0_data(s0_data), .s1_data(s1_data), .busy(busy)
  );

  // PHY model
  logic [15:0] mem [0:1023];
  logic sl_oe = 0, sl_d = 1;
  assign mdio_i = sl_oe ? sl_d : (mdio_oe ? mdio_o : 1'b1);
  int m_st = 0, pre_cnt = 0, hcnt = 0, tcnt = 0, dk = 0, fmt_err = 0;
  logic [12:0] hsh;
  logic [15:0] word;
  int lg_n = 0;
  int lg_phy [4], lg_reg [4], lg_pre [4];

  always @(posedge mdc) begin
    case (m_st)
      0: if (mdio_oe) begin
           if (mdio_o) pre_cnt++;
           else begin m_st = 1; hcnt = 0; end
         end
      1: begin
           if (!mdio_oe) fmt_err++;
           hsh = {hsh[11:0], mdio_o};
           hcnt++;
           if (hcnt == 13) begin
             if (hsh[12:10] != 3'b110) fmt_err++;
             if (lg_n < 4) begin
               lg_phy[lg_n] = int'(hsh[9:5]);
               lg_reg[lg_n] = int'(hsh[4:0]);
               lg_pre[lg_n] = pre_cnt;
             end
             m_st = 2; tcnt = 0;
           end
         end
      2: begin
           if (mdio_oe) fmt_err++;
           tcnt++;
           if (tcnt == 2) begin
             word = mem[{hsh[9:5], hsh[4:0]}];
             sl_oe = 1; sl_d = word[15]; dk = 1; m_st = 3;
           end
         end
      default: begin
           if (mdio_oe) fmt_err++;
           if (dk < 16) begin sl_d = word[15 - dk]; dk++; end
           else begin sl_oe = 0; m_st = 0; pre_cnt = 0; lg_n++; end
         end
    endcase
  end

  // MDC / MDIO timing monitor
  int tim_err = 0, last_rise = -1;
  logic p_mdc = 0, p_o = 1, p_oe = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ((mdio_o != p_o || mdio_oe != p_oe) && !(p_mdc && !mdc)) tim_err++;
      if (!p_mdc && mdc) begin
        if (last_rise >= 0 && cyc - last_rise != 2 * CLK_DIV) tim_err++;
        last_rise = cyc;
      end
    end
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench expectation model
  logic [15:0] e_ref [2];
  bit e_val [2];
  bit [1:0] e_irq = 0;

  function automatic int f_s1_phy();
    return s1_use_dflt ? int'(dflt_phy_addr) : int'(s1_phy_addr);
  endfunction
  function automatic int f_s1_pre();
    bit sup = s1_use_dflt ? dflt_no_pre_ok : s1_pre_sup;
    return sup ? 0 : 32;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) poll_tick = 1;
    @(negedge clk) poll_tick = 0;
  endtask

  task automatic clear(input bit [1:0] m);
    @(negedge clk) irq_clr = m;
    @(negedge clk) irq_clr = 0;
    e_irq &= ~m;
    step(1);
    check(irq == e_irq, "R8 clear", irq, e_irq);
  endtask

  task automatic do_round(input bit extra);
    bit act1 = slot1_en & ap_global_en;
    int nf = act1 ? 2 : 1;
    int p1 = f_s1_phy(), pr1 = f_s1_pre();
    int r1 = int'(s1_reg_addr);
    logic [15:0] v;
    if (!act1) e_val[1] = 0;
    lg_n = 0;
    pulse_tick();
    check(busy == 1, "R9 busy after tick", busy, 1);
    if (extra) begin step(100); pulse_tick(); end
    while (busy) @(negedge clk);
    step(3);
    check(lg_n == nf, "R2 frame count", lg_n, nf);
    check(lg_phy[0] == int'(dflt_phy_addr) && lg_reg[0] == 1, "R1/R9 slot0 addressing",
          lg_phy[0] * 32 + lg_reg[0], int'(dflt_phy_addr) * 32 + 1);
    check(lg_pre[0] == 32, "R1 slot0 preamble", lg_pre[0], 32);
    v = mem[{dflt_phy_addr, 5'd1}];
    if (e_val[0] && v != e_ref[0]) e_irq[0] = 1;
    e_ref[0] = v; e_val[0] = 1;
    if (act1) begin
      check(lg_phy[1] == p1 && lg_reg[1] == r1, "R3/R4 slot1 addressing",
            lg_phy[1] * 32 + lg_reg[1], p1 * 32 + r1);
      check(lg_pre[1] == pr1, "R3/R4 slot1 preamble", lg_pre[1], pr1);
      v = mem[{p1[4:0], r1[4:0]}];
      if (e_val[1] && v != e_ref[1]) e_irq[1] = 1;
      e_ref[1] = v; e_val[1] = 1;
    end
    check(s0_data == e_ref[0], "R10/R5 s0_data", s0_data, e_ref[0]);
    check(s1_data == e_ref[1], "R10/R5 s1_data", s1_data, e_ref[1]);
    check(irq == e_irq, "R7/R8 irq", irq, e_irq);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503) ^ 16'h5a5a;
    e_ref[0] = 0; e_ref[1] = 0; e_val[0] = 0; e_val[1] = 0;
    step(4);
    rst_n = 1;
    step(2);
    check(irq == 0 && busy == 0 && mdio_oe == 0, "R8 reset state",
          {irq, busy, mdio_oe}, 0);
    check(s0_data == 0 && s1_data == 0, "R10 reset data", s0_data | s1_data, 0);

    // R1 R7: first slot0 read primes only
    dflt_phy_addr = 5'd7;
    do_round(0);
    // R8: change, sticky, clear, unchanged
    mem[{5'd7, 5'd1}] = 16'h1234;
    do_round(0);
    do_round(0);
    clear(2'b01);
    do_round(0);
    // R2 gating
    slot1_en = 1; s1_phy_addr = 5'd19; s1_reg_addr = 5'd4;
    do_round(0);
    ap_global_en = 1;
    do_round(0);
    // R3 suppression, R9 mid-round tick
    s1_pre_sup = 1;
    mem[{5'd19, 5'd4}] = 16'hbeef;
    do_round(1);
    clear(2'b10);
    // R4 default substitution
    s1_use_dflt = 1; dflt_no_pre_ok = 0;
    do_round(0);
    dflt_no_pre_ok = 1;
    do_round(0);
    // R7 re-enable primes without interrupt
    slot1_en = 0; do_round(0);
    mem[{5'd7, 5'd4}] = 16'h0f0f;
    slot1_en = 1; do_round(0);
    clear(2'b11);

    for (int r = 0; r < 40; r++) begin
      dflt_phy_addr  = 5'($urandom);
      s1_phy_addr    = 5'($urandom);
      s1_reg_addr    = 5'($urandom);
      s1_pre_sup     = 1'($urandom);
      s1_use_dflt    = 1'($urandom);
      dflt_no_pre_ok = 1'($urandom);
      slot1_en       = ($urandom % 4) != 0;
      ap_global_en   = ($urandom % 4) != 0;
      if ($urandom % 2) mem[{dflt_phy_addr, 5'd1}] = 16'($urandom);
      if ($urandom % 2) mem[{s1_phy_addr, s1_reg_addr}] = 16'($urandom);
      if ($urandom % 2) mem[{dflt_phy_addr, s1_reg_addr}] = 16'($urandom);
      do_round(r % 7 == 3);
      if (r % 5 == 4) clear(2'($urandom));
    end

    check(fmt_err == 0, "R5 frame format", fmt_err, 0);
    check(tim_err == 0, "R6 MDC timing", tim_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    check(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule